// File: doc/BRIEF.md
# Timer Counter Clock Source Selector

This block is the front end of a 16-bit up-counter. It decides what advances the count. In internal mode the counter steps on every cycle of the system clock while the run bit is set. In external edge mode it steps once for each qualifying edge of one chosen trigger line. Four candidate lines arrive at the block: a raw pin, two already-filtered inputs and an external trigger signal. Each passes through a two-flop resynchronizer. A previous-sample register then turns it into single-cycle rise and fall pulses. A source-select field picks one line, and a polarity bit picks which edge counts. The raw pin is the exception: it counts on both edges.

Each selected trigger edge sets a sticky trigger flag. The flag stays set until software clears it. An interrupt line follows the flag, gated by an enable bit. A one-cycle software update strobe is registered once and then clears the counter. The asynchronous active-low reset is released through a two-stage reset synchronizer.

Top module: `tmr_clksel_top`

## Requirements
- R1: When `cfg_mode` is any value other than 3'b111 and `cfg_run` is 1, `cnt` increases by exactly one on every rising clock edge. Values 3'b001 to 3'b110 behave like 3'b000.
- R2: When `cfg_run` is 0, `cnt` holds its value in every mode, including while selected trigger edges arrive.
- R3: A one-cycle `upd_req` pulse leaves `cnt` unchanged at the first rising edge after it and forces `cnt` to 0 at the second. The clear takes priority over counting on that edge.
- R4: When `cfg_mode` is 3'b111 and `cfg_run` is 1, `cnt` increases by one for each selected edge. The new value is visible after the third rising clock edge that follows the input change.
- R5: `cfg_src` picks the trigger line:
  - 3'b100 selects `pin_raw` on both edges.
  - 3'b101 selects `filt_a`.
  - 3'b110 selects `filt_b`.
  - 3'b111 selects `xtrig_in`.
  - 3'b000 to 3'b011 select no line.
  - Lines that are not selected have no effect on `cnt` or `trig_flag`.
- R6: For `cfg_src` 3'b101 to 3'b111, `cfg_pol` = 0 counts rising edges and `cfg_pol` = 1 counts falling edges. Edges of the other direction are ignored.
- R7: Each selected edge sets `trig_flag` in any mode and with any `cfg_run`. The flag stays set until a cycle with `flag_clr` = 1 and no selected edge clears it. When a set and a clear meet in the same cycle, the set wins.
- R8: `irq` is 1 exactly while `trig_flag` is 1 and `irq_en` is 1.
- R9: `cnt` wraps from 16'hFFFF to 16'h0000 on the next counting step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_run | input | 1 | Count enable |
| cfg_mode | input | 3 | Clocking mode; 3'b111 selects external edge counting |
| cfg_src | input | 3 | Trigger line select |
| cfg_pol | input | 1 | Edge polarity: 0 rising, 1 falling |
| upd_req | input | 1 | One-cycle software update strobe that clears the counter |
| flag_clr | input | 1 | Software clear of the trigger flag |
| irq_en | input | 1 | Trigger interrupt enable |
| pin_raw | input | 1 | Raw asynchronous trigger pin |
| filt_a | input | 1 | First filtered trigger input |
| filt_b | input | 1 | Second filtered trigger input |
| xtrig_in | input | 1 | External trigger signal |
| cnt | output | 16 | Counter value |
| trig_flag | output | 1 | Sticky trigger flag |
| irq | output | 1 | Trigger interrupt request |

## Verification
Internal counting is tried in mode 000 and in an unused mode value, to tell "any non-111 mode counts every cycle" apart from "only 000 counts". External counting is tried with a table of edges:
- a rise and a fall on each selected line under both polarities, which separates a working polarity select from a stuck one;
- an edge on an unselected line, and an edge with a source value that selects nothing, which show that the multiplexer isolates the lines;
- both directions on the raw pin, which distinguishes both-edge detection from single-edge detection.

Directed cases cover:
- the exact three-cycle latency of a counted edge;
- the two-cycle delay of the update clear;
- counter hold with edges arriving;
- flag stickiness, and set winning over clear;
- the interrupt gate;
- the 16'hFFFF wrap.

// File: rtl/tmr_clksel_pkg.sv
package tmr_clksel_pkg;

  localparam int LANES = 4;

  localparam int LANE_RAW  = 0;
  localparam int LANE_FA   = 1;
  localparam int LANE_FB   = 2;
  localparam int LANE_XTRG = 3;

  localparam logic [2:0] MODE_EXT_EDGE = 3'b111;

  localparam logic [2:0] SRC_RAW_BOTH = 3'b100;
  localparam logic [2:0] SRC_FA       = 3'b101;
  localparam logic [2:0] SRC_FB       = 3'b110;
  localparam logic [2:0] SRC_XTRG     = 3'b111;

endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
  parameter int LANES  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] din,
  output logic [LANES-1:0] rise,
  output logic [LANES-1:0] fall
);

  localparam int MSB = STAGES - 1;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [STAGES-1:0] sh_q;
    logic [STAGES-1:0] sh_d;
    logic              prev_q;
    logic              prev_d;

    // next-state: shift the raw level in, remember the last settled sample
    always_comb begin
      sh_d   = {sh_q[STAGES-2:0], din[g]};
      prev_d = sh_q[MSB];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q   <= '0;
        prev_q <= 1'b0;
      end else begin
        sh_q   <= sh_d;
        prev_q <= prev_d;
      end
    end

    assign rise[g] =  sh_q[MSB] & ~prev_q;
    assign fall[g] = ~sh_q[MSB] &  prev_q;
  end

endmodule

// File: rtl/tmr_trig_sel.sv
module tmr_trig_sel
  import tmr_clksel_pkg::*;
(
  input  logic [2:0]       src,
  input  logic             pol,
  input  logic [LANES-1:0] rise,
  input  logic [LANES-1:0] fall,
  output logic             trig_pulse
);

  always_comb begin
    trig_pulse = 1'b0;
    case (src)
      SRC_RAW_BOTH: trig_pulse = rise[LANE_RAW] | fall[LANE_RAW];
      SRC_FA:       trig_pulse = pol ? fall[LANE_FA]   : rise[LANE_FA];
      SRC_FB:       trig_pulse = pol ? fall[LANE_FB]   : rise[LANE_FB];
      SRC_XTRG:     trig_pulse = pol ? fall[LANE_XTRG] : rise[LANE_XTRG];
      default:      trig_pulse = 1'b0;
    endcase
  end

endmodule

// File: rtl/tmr_cnt_core.sv
module tmr_cnt_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             ext_mode,
  input  logic             trig_pulse,
  input  logic             upd_req,
  output logic [CNT_W-1:0] cnt
);

  logic             upd_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             step;
  logic             cnt_en;

  // update strobe is registered once before it acts on the counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upd_q <= 1'b0;
    else        upd_q <= upd_req;
  end

  always_comb begin
    step   = run & (ext_mode ? trig_pulse : 1'b1);
    cnt_en = upd_q | step;
    if (upd_q) cnt_d = '0;
    else       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/tmr_trig_flag.sv
module tmr_trig_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);

  logic flag_q;
  logic flag_d;

  always_comb begin
    if (set)      flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
    else          flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

endmodule

// File: rtl/tmr_clksel_top.sv
module tmr_clksel_top
  import tmr_clksel_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_run,
  input  logic [2:0]       cfg_mode,
  input  logic [2:0]       cfg_src,
  input  logic             cfg_pol,
  input  logic             upd_req,
  input  logic             flag_clr,
  input  logic             irq_en,
  input  logic             pin_raw,
  input  logic             filt_a,
  input  logic             filt_b,
  input  logic             xtrig_in,
  output logic [CNT_W-1:0] cnt,
  output logic             trig_flag,
  output logic             irq
);

  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  logic [LANES-1:0] lane_in;
  logic [LANES-1:0] lane_rise;
  logic [LANES-1:0] lane_fall;
  logic             trig_pulse;
  logic             ext_mode;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  always_comb begin
    lane_in            = '0;
    lane_in[LANE_RAW]  = pin_raw;
    lane_in[LANE_FA]   = filt_a;
    lane_in[LANE_FB]   = filt_b;
    lane_in[LANE_XTRG] = xtrig_in;
  end

  assign ext_mode = (cfg_mode == MODE_EXT_EDGE);

  tmr_sync_edge #(.LANES(LANES), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_core_n),
    .din  (lane_in),
    .rise (lane_rise),
    .fall (lane_fall)
  );

  tmr_trig_sel u_sel (
    .src       (cfg_src),
    .pol       (cfg_pol),
    .rise      (lane_rise),
    .fall      (lane_fall),
    .trig_pulse(trig_pulse)
  );

  tmr_cnt_core #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .run       (cfg_run),
    .ext_mode  (ext_mode),
    .trig_pulse(trig_pulse),
    .upd_req   (upd_req),
    .cnt       (cnt)
  );

  tmr_trig_flag u_flag (
    .clk  (clk),
    .rst_n(rst_core_n),
    .set  (trig_pulse),
    .clr  (flag_clr),
    .flag (trig_flag)
  );

  assign irq = trig_flag & irq_en;

endmodule

// File: rtl/tmr_clksel_chk.sv
module tmr_clksel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_core_n,
  input logic             cfg_run,
  input logic [2:0]       cfg_mode,
  input logic             upd_req,
  input logic             flag_clr,
  input logic             irq_en,
  input logic [CNT_W-1:0] cnt,
  input logic             trig_flag,
  input logic             irq,
  input logic             trig_pulse
);

  assert_int_step_R1: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cfg_mode != 3'b111 && cfg_run && !$past(upd_req))
      |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!cfg_run && !$past(upd_req)) |=> $stable(cnt));

  assert_upd_clear_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    upd_req |=> ##1 (cnt == '0));

  assert_ext_step_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cfg_mode == 3'b111 && !$past(upd_req))
      |=> (cnt == $past(cnt) || cnt == CNT_W'($past(cnt) + 1'b1)));

  assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    trig_pulse |=> trig_flag);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (trig_flag && !flag_clr) |=> trig_flag);

  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (flag_clr && !trig_pulse) |=> !trig_flag);

  assert_irq_follow_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    ($rose(trig_flag) && irq_en) |-> irq);

endmodule

bind tmr_clksel_top tmr_clksel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_core_n(rst_core_n),
  .cfg_run   (cfg_run),
  .cfg_mode  (cfg_mode),
  .upd_req   (upd_req),
  .flag_clr  (flag_clr),
  .irq_en    (irq_en),
  .cnt       (cnt),
  .trig_flag (trig_flag),
  .irq       (irq),
  .trig_pulse(trig_pulse)
);

// File: tb/tmr_clksel_top_test.sv
module tmr_clksel_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;
  localparam int NVEC       = 13;

  // vector fields: mode[11:9] src[8:6] pol[5] lane[4:3] level[2] exp_cnt[1] exp_flag[0]
  localparam logic [11:0] VEC [NVEC] = '{
    12'b111_110_0_10_1_1_1,
    12'b111_110_0_10_0_0_0,
    12'b111_110_1_10_0_1_1,
    12'b111_110_1_10_1_0_0,
    12'b111_101_0_01_1_1_1,
    12'b111_101_1_01_1_0_0,
    12'b111_111_0_11_1_1_1,
    12'b111_111_1_11_0_1_1,
    12'b111_100_0_00_1_1_1,
    12'b111_100_0_00_0_1_1,
    12'b111_100_1_00_1_1_1,
    12'b111_110_0_01_1_0_0,
    12'b111_000_0_00_1_0_0
  };

  logic        clk;
  logic        rst_n;
  logic        cfg_run;
  logic [2:0]  cfg_mode;
  logic [2:0]  cfg_src;
  logic        cfg_pol;
  logic        upd_req;
  logic        flag_clr;
  logic        irq_en;
  logic [3:0]  pins;
  logic [15:0] cnt;
  logic        trig_flag;
  logic        irq;

  int checks;
  int failures;
  logic [15:0] snap;

  tmr_clksel_top uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_run  (cfg_run),
    .cfg_mode (cfg_mode),
    .cfg_src  (cfg_src),
    .cfg_pol  (cfg_pol),
    .upd_req  (upd_req),
    .flag_clr (flag_clr),
    .irq_en   (irq_en),
    .pin_raw  (pins[0]),
    .filt_a   (pins[1]),
    .filt_b   (pins[2]),
    .xtrig_in (pins[3]),
    .cnt      (cnt),
    .trig_flag(trig_flag),
    .irq      (irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_upd_clr;
    upd_req  = 1'b1;
    flag_clr = 1'b1;
    tick(1);
    upd_req  = 1'b0;
    flag_clr = 1'b0;
    tick(3);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    failures++;
    $display("FAIL WDOG actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0;
    rst_n = 1'b0; cfg_run = 1'b0; cfg_mode = 3'b000; cfg_src = 3'b000;
    cfg_pol = 1'b0; upd_req = 1'b0; flag_clr = 1'b0; irq_en = 1'b0; pins = 4'b0000;
    tick(3);
    rst_n = 1'b1;
    tick(3);
    check("RST cnt", cnt, 0);
    check("RST flag", trig_flag, 0);
    check("RST irq", irq, 0);

    // R1: internal counting in mode 000 and in an unused mode value
    cfg_mode = 3'b000; cfg_run = 1'b1;
    tick(2); snap = cnt; tick(5);
    check("R1 mode000", cnt, 32'(snap + 16'd5));
    cfg_mode = 3'b010;
    snap = cnt; tick(4);
    check("R1 mode010", cnt, 32'(snap + 16'd4));

    // R2: halted counter holds, also while trigger edges arrive
    cfg_run = 1'b0;
    snap = cnt; tick(6);
    check("R2 hold int", cnt, snap);
    cfg_mode = 3'b111; cfg_src = 3'b110; cfg_pol = 1'b0;
    tick(2);
    pins[2] = 1'b1;
    tick(3);
    check("R2 hold ext", cnt, snap);
    check("R7 flag while halted", trig_flag, 1);
    check("R8 irq gated off", irq, 0);
    irq_en = 1'b1; #1;
    check("R8 irq on", irq, 1);

    // R7: stickiness and clear
    tick(10);
    check("R7 sticky", trig_flag, 1);
    flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
    check("R7 cleared", trig_flag, 0);
    check("R8 irq drops", irq, 0);

    // R7: set wins over a clear in the same cycle
    pins[2] = 1'b0; tick(5);
    check("R6 falling ignored pol0", trig_flag, 0);
    pins[2] = 1'b1; tick(2);
    flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
    check("R7 set wins", trig_flag, 1);

    // R3: clear arrives on the second edge after the strobe
    snap = cnt;
    upd_req = 1'b1; tick(1); upd_req = 1'b0;
    check("R3 not yet cleared", cnt, snap);
    tick(1);
    check("R3 cleared", cnt, 0);
    cfg_mode = 3'b000; cfg_run = 1'b1; tick(3);
    upd_req = 1'b1; tick(1); upd_req = 1'b0;
    tick(1);
    check("R3 clear beats count", cnt, 0);
    tick(1);
    check("R3 counts after clear", cnt, 1);

    // R4/R5/R6/R7: edge table
    for (int i = 0; i < NVEC; i++) begin
      logic [11:0] v;
      int ln;
      v = VEC[i];
      ln = int'(v[4:3]);
      cfg_mode = v[11:9]; cfg_src = v[8:6]; cfg_pol = v[5]; cfg_run = 1'b1;
      pins[ln] = ~v[2];
      tick(5);
      pulse_upd_clr();
      pins[ln] = v[2];
      tick(3);
      check($sformatf("R4/R5/R6 vec%0d cnt", i), cnt, {31'd0, v[1]});
      check($sformatf("R7 vec%0d flag", i), trig_flag, {31'd0, v[0]});
    end

    // R4: exact latency
    cfg_mode = 3'b111; cfg_src = 3'b101; cfg_pol = 1'b0;
    pins[1] = 1'b0; tick(5); pulse_upd_clr();
    pins[1] = 1'b1; tick(2);
    check("R4 not before third edge", cnt, 0);
    tick(1);
    check("R4 at third edge", cnt, 1);

    // R9: wrap
    cfg_mode = 3'b000; cfg_run = 1'b0;
    upd_req = 1'b1; tick(1); upd_req = 1'b0; tick(2);
    cfg_run = 1'b1; tick(65535); cfg_run = 1'b0;
    check("R9 top value", cnt, 32'h0000FFFF);
    cfg_run = 1'b1; tick(1); cfg_run = 1'b0;
    check("R9 wraps", cnt, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule